// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Unit

This block sits beside a processor core and decides, at each point where the core offers to accept an interrupt, whether the pending interrupt level is accepted. When it is, the block performs the state changes the core would make: it saves the interrupted PC and status word, rewrites the status word, records an exception cause, and reports a target address together with a dispatch class.

Levels above 1 are high-priority interrupts. Each of them has its own PC save slot and status save slot, and each jumps straight to its own vector. Level 1 is handled as an ordinary exception instead. The status bits select a user, kernel or double exception, and the level-1 cause code is recorded.

The vector addresses are build-time parameters. When vector relocation is enabled, each target is moved relative to a runtime vector-base input. The core writes the status word back through a load port, for example on a return from an exception.

Top module: `irq_dispatch`

## Requirements
- R1: After a synchronous reset the status word reads 0x1F when the interrupt option parameter is set and 0x10 when it is not. The taken pulse, every save slot, the double-exception save register and the cause are all zero. The registered pending level is cleared.
- R2: The pending level input is registered at every clock edge. When `eval_i` is high, the registered level L is accepted only if all of the following hold: L is above the status INTLEVEL field (bits 3:0), L is no greater than NLEVEL, and level L's mask ANDed with `int_set_i` and `int_en_i` is non-zero. Level L's mask is slot L-1 of `lvl_mask_i`.
- R3: When no level is accepted, `taken_o` stays 0 and the status word, all save slots, the double-exception save register, the cause, the target and the class keep their values.
- R4: Accepting a level L>1 has three effects. The PC is stored in slot L-1 of `epc_o`. The old status word is stored in slot L-2 of `eps_o`. The new status word is the old one with INTLEVEL set to L and EXCM (bit 4) set, and bits 7:5 are kept.
- R5: Accepting a level L>1 gives class 0 (high-priority). The default target is `VEC_L2 + (L-2)*VEC_STRIDE`.
- R6: Accepting level 1 with EXCM clear has four effects. The cause is set to LVL1_CAUSE (4). The PC is stored in slot 0 of `epc_o`. EXCM is set. The class is 1 (user, target USER_VEC) when UM (bit 5) is set, and 2 (kernel, target KERN_VEC) otherwise.
- R7: Accepting level 1 with EXCM already set gives class 3 (double, target DBL_VEC) and sets the cause to 4. The PC goes to `depc_o` when HAS_DEPC is set and leaves slot 0 of `epc_o` unchanged. When HAS_DEPC is clear, the PC goes to slot 0 of `epc_o`.
- R8: With RELOC_EN set, the reported target is the default vector minus DEF_VECBASE plus `vecbase_i`. With RELOC_EN clear, the reported target is the default vector itself.
- R9: `taken_o` is high for exactly the one cycle that follows the accepting edge, and every register update appears on that same edge. When an acceptance and a status write fall on the same edge, the acceptance wins.
- R10: When `ps_wr_i` is high and no level is accepted, the status word loads `ps_wdata_i` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Core offers to accept an interrupt this cycle |
| pend_lvl_i | input | LVLW | Pending interrupt level, registered every edge |
| lvl_mask_i | input | NLEVEL*NIRQ | Per-level interrupt masks, slot L-1 for level L |
| int_set_i | input | NIRQ | Interrupt-set register |
| int_en_i | input | NIRQ | Interrupt-enable register |
| pc_i | input | XLEN | PC of the interrupted instruction |
| vecbase_i | input | XLEN | Runtime vector base |
| ps_wr_i | input | 1 | Status word load strobe |
| ps_wdata_i | input | 8 | Status word load value |
| taken_o | output | 1 | One-cycle acceptance pulse |
| class_o | output | 2 | 0 high, 1 user, 2 kernel, 3 double |
| target_o | output | XLEN | Address to redirect to |
| ps_o | output | 8 | Status word |
| exccause_o | output | CAUSEW | Exception cause |
| epc_o | output | NLEVEL*XLEN | PC save slots, slot L-1 for level L |
| eps_o | output | (NLEVEL-1)*8 | Status save slots, slot L-2 for level L |
| depc_o | output | XLEN | Double-exception PC save |

## Verification
A wrong qualification decision shows up one cycle after `eval_i` in two ways: `taken_o` misbehaves, and so does the status word, which either rises to a new INTLEVEL or fails to. A wrong class choice or a wrong save-slot index shows in the same cycle as a misplaced PC in `epc_o` or `depc_o`, together with a wrong class and target. A relocation error shows only in `target_o`, so every dispatch class is run with a base that differs from the default. A variant instance without relocation, without the double-exception save register and without the interrupt option covers the other configuration branches.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  localparam int PSW       = 8;
  localparam int PS_LVL_W  = 4;
  localparam int PS_EXCM   = 4;
  localparam int PS_UM     = 5;

  typedef enum logic [1:0] {
    CLS_HIGH = 2'd0,
    CLS_USER = 2'd1,
    CLS_KERN = 2'd2,
    CLS_DBL  = 2'd3
  } disp_cls_e;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int unsigned NLEVEL = 6,
  parameter int unsigned NIRQ   = 32,
  parameter int unsigned LVLW   = 4
) (
  input  logic                   eval_i,
  input  logic [LVLW-1:0]        pend_lvl_i,
  input  logic [LVLW-1:0]        cur_lvl_i,
  input  logic [NLEVEL*NIRQ-1:0] lvl_mask_i,
  input  logic [NIRQ-1:0]        int_set_i,
  input  logic [NIRQ-1:0]        int_en_i,
  output logic                   accept_o
);
  logic [NIRQ-1:0]   live;
  logic [NLEVEL-1:0] lvl_hit;
  logic              hit_sel;
  logic              in_range;

  assign live = int_set_i & int_en_i;

  for (genvar g = 0; g < NLEVEL; g++) begin : g_hit
    assign lvl_hit[g] = |(lvl_mask_i[g*NIRQ +: NIRQ] & live);
  end

  always_comb begin
    hit_sel = 1'b0;
    for (int l = 1; l <= NLEVEL; l++) begin
      if (pend_lvl_i == LVLW'(l)) hit_sel = lvl_hit[l-1];
    end
  end

  assign in_range = (pend_lvl_i <= LVLW'(NLEVEL));
  assign accept_o = eval_i && in_range && (pend_lvl_i > cur_lvl_i) && hit_sel;
endmodule

// File: rtl/irq_vector.sv
module irq_vector
  import irq_disp_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     LVLW        = 4,
  parameter bit              RELOC_EN    = 1'b1,
  parameter logic [XLEN-1:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [XLEN-1:0] VEC_L2      = 32'h4000_0180,
  parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0040,
  parameter logic [XLEN-1:0] USER_VEC    = 32'h4000_0340,
  parameter logic [XLEN-1:0] KERN_VEC    = 32'h4000_0300,
  parameter logic [XLEN-1:0] DBL_VEC     = 32'h4000_03C0
) (
  input  logic [LVLW-1:0] lvl_i,
  input  disp_cls_e       cls_i,
  input  logic [XLEN-1:0] vecbase_i,
  output logic [XLEN-1:0] target_o
);
  logic [XLEN-1:0] def_vec;
  logic [XLEN-1:0] hi_vec;

  assign hi_vec = VEC_L2 + (XLEN'(lvl_i) - XLEN'(2)) * VEC_STRIDE;

  always_comb begin
    unique case (cls_i)
      CLS_HIGH: def_vec = hi_vec;
      CLS_USER: def_vec = USER_VEC;
      CLS_KERN: def_vec = KERN_VEC;
      default:  def_vec = DBL_VEC;
    endcase
  end

  if (RELOC_EN) begin : g_reloc
    assign target_o = def_vec - DEF_VECBASE + vecbase_i;
  end else begin : g_fixed
    logic [XLEN-1:0] unused_base;
    assign unused_base = vecbase_i;
    assign target_o    = def_vec;
  end
endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs
  import irq_disp_pkg::*;
#(
  parameter int unsigned NLEVEL   = 6,
  parameter int unsigned XLEN     = 32,
  parameter int unsigned LVLW     = 4,
  parameter bit          HAS_DEPC = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       take_i,
  input  logic [LVLW-1:0]            lvl_i,
  input  disp_cls_e                  cls_i,
  input  logic [XLEN-1:0]            pc_i,
  input  logic [PSW-1:0]             ps_old_i,
  output logic [NLEVEL*XLEN-1:0]     epc_o,
  output logic [(NLEVEL-1)*PSW-1:0]  eps_o,
  output logic [XLEN-1:0]            depc_o
);
  logic dbl_to_depc;
  assign dbl_to_depc = HAS_DEPC && (cls_i == CLS_DBL);

  for (genvar g = 0; g < NLEVEL; g++) begin : g_lvl
    logic            wr;
    logic [XLEN-1:0] epc_q;
    if (g == 0) begin : g_l1
      assign wr = take_i && (lvl_i == LVLW'(1)) && !dbl_to_depc;
    end else begin : g_hi
      logic [PSW-1:0] eps_q;
      assign wr = take_i && (lvl_i == LVLW'(g + 1));
      always_ff @(posedge clk) begin
        if (rst)     eps_q <= '0;
        else if (wr) eps_q <= ps_old_i;
      end
      assign eps_o[(g-1)*PSW +: PSW] = eps_q;
    end
    always_ff @(posedge clk) begin
      if (rst)     epc_q <= '0;
      else if (wr) epc_q <= pc_i;
    end
    assign epc_o[g*XLEN +: XLEN] = epc_q;
  end

  if (HAS_DEPC) begin : g_depc
    logic [XLEN-1:0] depc_q;
    always_ff @(posedge clk) begin
      if (rst)                          depc_q <= '0;
      else if (take_i && dbl_to_depc)   depc_q <= pc_i;
    end
    assign depc_o = depc_q;
  end else begin : g_nodepc
    assign depc_o = '0;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_disp_pkg::*;
#(
  parameter int unsigned     NLEVEL      = 6,
  parameter int unsigned     NIRQ        = 32,
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     LVLW        = 4,
  parameter int unsigned     CAUSEW      = 6,
  parameter int unsigned     LVL1_CAUSE  = 4,
  parameter bit              HAS_INT_OPT = 1'b1,
  parameter bit              HAS_DEPC    = 1'b1,
  parameter bit              RELOC_EN    = 1'b1,
  parameter logic [XLEN-1:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [XLEN-1:0] VEC_L2      = 32'h4000_0180,
  parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0040,
  parameter logic [XLEN-1:0] USER_VEC    = 32'h4000_0340,
  parameter logic [XLEN-1:0] KERN_VEC    = 32'h4000_0300,
  parameter logic [XLEN-1:0] DBL_VEC     = 32'h4000_03C0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      eval_i,
  input  logic [LVLW-1:0]           pend_lvl_i,
  input  logic [NLEVEL*NIRQ-1:0]    lvl_mask_i,
  input  logic [NIRQ-1:0]           int_set_i,
  input  logic [NIRQ-1:0]           int_en_i,
  input  logic [XLEN-1:0]           pc_i,
  input  logic [XLEN-1:0]           vecbase_i,
  input  logic                      ps_wr_i,
  input  logic [7:0]                ps_wdata_i,
  output logic                      taken_o,
  output logic [1:0]                class_o,
  output logic [XLEN-1:0]           target_o,
  output logic [7:0]                ps_o,
  output logic [CAUSEW-1:0]         exccause_o,
  output logic [NLEVEL*XLEN-1:0]    epc_o,
  output logic [(NLEVEL-1)*8-1:0]   eps_o,
  output logic [XLEN-1:0]           depc_o
);
  localparam logic [PSW-1:0] PS_RESET = HAS_INT_OPT ? 8'h1F : 8'h10;

  logic [LVLW-1:0]   pend_q;
  logic [PSW-1:0]    ps_q;
  logic              taken_q;
  disp_cls_e         cls_q;
  logic [XLEN-1:0]   target_q;
  logic [CAUSEW-1:0] cause_q;

  logic              accept;
  disp_cls_e         cls_d;
  logic [XLEN-1:0]   target_d;
  logic [PSW-1:0]    ps_d;
  logic              is_hi;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_lvl_i;
  end

  irq_qualify #(.NLEVEL(NLEVEL), .NIRQ(NIRQ), .LVLW(LVLW)) u_qual (
    .eval_i     (eval_i),
    .pend_lvl_i (pend_q),
    .cur_lvl_i  (LVLW'(ps_q[PS_LVL_W-1:0])),
    .lvl_mask_i (lvl_mask_i),
    .int_set_i  (int_set_i),
    .int_en_i   (int_en_i),
    .accept_o   (accept)
  );

  assign is_hi = (pend_q > LVLW'(1));

  always_comb begin
    if (is_hi)              cls_d = CLS_HIGH;
    else if (ps_q[PS_EXCM]) cls_d = CLS_DBL;
    else if (ps_q[PS_UM])   cls_d = CLS_USER;
    else                    cls_d = CLS_KERN;
  end

  always_comb begin
    ps_d = ps_q;
    ps_d[PS_EXCM] = 1'b1;
    if (is_hi) ps_d[PS_LVL_W-1:0] = PS_LVL_W'(pend_q);
  end

  irq_vector #(
    .XLEN(XLEN), .LVLW(LVLW), .RELOC_EN(RELOC_EN), .DEF_VECBASE(DEF_VECBASE),
    .VEC_L2(VEC_L2), .VEC_STRIDE(VEC_STRIDE), .USER_VEC(USER_VEC),
    .KERN_VEC(KERN_VEC), .DBL_VEC(DBL_VEC)
  ) u_vec (
    .lvl_i     (pend_q),
    .cls_i     (cls_d),
    .vecbase_i (vecbase_i),
    .target_o  (target_d)
  );

  irq_save_regs #(
    .NLEVEL(NLEVEL), .XLEN(XLEN), .LVLW(LVLW), .HAS_DEPC(HAS_DEPC)
  ) u_save (
    .clk      (clk),
    .rst      (rst),
    .take_i   (accept),
    .lvl_i    (pend_q),
    .cls_i    (cls_d),
    .pc_i     (pc_i),
    .ps_old_i (ps_q),
    .epc_o    (epc_o),
    .eps_o    (eps_o),
    .depc_o   (depc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q     <= PS_RESET;
      taken_q  <= 1'b0;
      cls_q    <= CLS_HIGH;
      target_q <= '0;
      cause_q  <= '0;
    end else begin
      taken_q <= accept;
      if (accept) begin
        ps_q     <= ps_d;
        cls_q    <= cls_d;
        target_q <= target_d;
        if (!is_hi) cause_q <= CAUSEW'(LVL1_CAUSE);
      end else if (ps_wr_i) begin
        ps_q <= ps_wdata_i;
      end
    end
  end

  assign taken_o    = taken_q;
  assign class_o    = cls_q;
  assign target_o   = target_q;
  assign ps_o       = ps_q;
  assign exccause_o = cause_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int unsigned NLEVEL = 6,
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CAUSEW = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   eval_i,
  input logic                   taken_o,
  input logic [1:0]             class_o,
  input logic [7:0]             ps_o,
  input logic [CAUSEW-1:0]      exccause_o,
  input logic [NLEVEL*XLEN-1:0] epc_o,
  input logic [XLEN-1:0]        depc_o
);
  // R9
  taken_needs_eval_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> $past(eval_i));

  // R6
  excm_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> ps_o[4]);

  // R4
  hi_level_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && class_o == 2'd0) |-> (ps_o[3:0] > $past(ps_o[3:0])));

  // R7
  double_needs_excm_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && class_o == 2'd3) |-> $past(ps_o[4]));

  // R6
  user_needs_um_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && class_o == 2'd1) |-> ($past(ps_o[5]) && !$past(ps_o[4])));

  // R3
  idle_saves_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> ($stable(epc_o) && $stable(depc_o) && $stable(exccause_o)));
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .NLEVEL(NLEVEL), .XLEN(XLEN), .CAUSEW(CAUSEW)
) u_chk (
  .clk(clk), .rst(rst), .eval_i(eval_i), .taken_o(taken_o), .class_o(class_o),
  .ps_o(ps_o), .exccause_o(exccause_o), .epc_o(epc_o), .depc_o(depc_o)
);

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NLEVEL = 6;
  localparam int NIRQ   = 32;
  localparam int XLEN   = 32;
  localparam int LVLW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eval_i = 1'b0;
  logic [LVLW-1:0] pend_lvl_i = '0;
  logic [NLEVEL*NIRQ-1:0] lvl_mask_i;
  logic [NIRQ-1:0] int_set_i = '0;
  logic [NIRQ-1:0] int_en_i = '0;
  logic [XLEN-1:0] pc_i = '0;
  logic [XLEN-1:0] vecbase_i = 32'h8000_0000;
  logic ps_wr_i = 1'b0;
  logic [7:0] ps_wdata_i = '0;

  logic taken, a_taken;
  logic [1:0] cls, a_cls;
  logic [XLEN-1:0] tgt, a_tgt, depc, a_depc;
  logic [7:0] ps, a_ps;
  logic [5:0] cause, a_cause;
  logic [NLEVEL*XLEN-1:0] epc, a_epc;
  logic [(NLEVEL-1)*8-1:0] eps, a_eps;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int l = 0; l < NLEVEL; l++) lvl_mask_i[l*NIRQ +: NIRQ] = 32'h1 << (l + 1);
  end

  irq_dispatch #(.NLEVEL(NLEVEL), .NIRQ(NIRQ), .XLEN(XLEN), .LVLW(LVLW)) u_dut (
    .clk(clk), .rst(rst), .eval_i(eval_i), .pend_lvl_i(pend_lvl_i),
    .lvl_mask_i(lvl_mask_i), .int_set_i(int_set_i), .int_en_i(int_en_i),
    .pc_i(pc_i), .vecbase_i(vecbase_i), .ps_wr_i(ps_wr_i), .ps_wdata_i(ps_wdata_i),
    .taken_o(taken), .class_o(cls), .target_o(tgt), .ps_o(ps),
    .exccause_o(cause), .epc_o(epc), .eps_o(eps), .depc_o(depc)
  );

  irq_dispatch #(.NLEVEL(NLEVEL), .NIRQ(NIRQ), .XLEN(XLEN), .LVLW(LVLW),
                 .HAS_INT_OPT(1'b0), .HAS_DEPC(1'b0), .RELOC_EN(1'b0)) u_alt (
    .clk(clk), .rst(rst), .eval_i(eval_i), .pend_lvl_i(pend_lvl_i),
    .lvl_mask_i(lvl_mask_i), .int_set_i(int_set_i), .int_en_i(int_en_i),
    .pc_i(pc_i), .vecbase_i(vecbase_i), .ps_wr_i(ps_wr_i), .ps_wdata_i(ps_wdata_i),
    .taken_o(a_taken), .class_o(a_cls), .target_o(a_tgt), .ps_o(a_ps),
    .exccause_o(a_cause), .epc_o(a_epc), .eps_o(a_eps), .depc_o(a_depc)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] epc_slot(int lvl);
    return epc[(lvl-1)*XLEN +: XLEN];
  endfunction

  function automatic logic [7:0] eps_slot(int lvl);
    return eps[(lvl-2)*8 +: 8];
  endfunction

  task automatic write_ps(logic [7:0] v);
    @(negedge clk);
    ps_wr_i = 1'b1; ps_wdata_i = v;
    @(negedge clk);
    ps_wr_i = 1'b0;
  endtask

  // drive pending level, wait for it to register, then offer for one cycle
  task automatic offer(int lvl, logic [NIRQ-1:0] set, logic [NIRQ-1:0] en,
                       logic [XLEN-1:0] pc, bit wr_ps = 0, logic [7:0] wv = 0);
    @(negedge clk);
    pend_lvl_i = LVLW'(lvl); int_set_i = set; int_en_i = en; pc_i = pc;
    @(negedge clk);
    eval_i = 1'b1;
    if (wr_ps) begin ps_wr_i = 1'b1; ps_wdata_i = wv; end
    @(negedge clk);
    eval_i = 1'b0; ps_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ps", ps, 8'h1F);
    chk("R1", "alt ps", a_ps, 8'h10);
    chk("R1", "taken", taken, 0);
    chk("R1", "epc", epc, 0);
    chk("R1", "depc", depc, 0);
    chk("R1", "cause", cause, 0);
  endtask

  task automatic t_alt_double();
    offer(1, 32'h2, 32'h2, 32'h100);
    chk("R7", "alt taken", a_taken, 1);
    chk("R7", "alt class", a_cls, 3);
    chk("R7", "alt epc1", a_epc[XLEN-1:0], 32'h100);
    chk("R8", "alt unrelocated target", a_tgt, 32'h4000_03C0);
    chk("R7", "alt cause", a_cause, 4);
    chk("R2", "level under 15 refused", taken, 0);
    chk("R3", "ps kept", ps, 8'h1F);
  endtask

  task automatic t_high3();
    write_ps(8'h00);
    offer(3, 32'h8, 32'h8, 32'h1000);
    chk("R9", "taken", taken, 1);
    chk("R5", "class", cls, 0);
    chk("R4", "ps", ps, 8'h13);
    chk("R4", "epc3", epc_slot(3), 32'h1000);
    chk("R4", "eps3", eps_slot(3), 8'h00);
    chk("R8", "target", tgt, 32'h8000_01C0);
    @(negedge clk);
    chk("R9", "pulse ends", taken, 0);
  endtask

  task automatic t_not_above();
    offer(2, 32'h4, 32'h4, 32'h1100);
    chk("R2", "lower level refused", taken, 0);
    chk("R3", "ps kept", ps, 8'h13);
    chk("R3", "epc2 kept", epc_slot(2), 0);
    chk("R3", "target kept", tgt, 32'h8000_01C0);
  endtask

  task automatic t_masked();
    write_ps(8'h00);
    offer(6, 32'h40, 32'h00, 32'h1200);
    chk("R2", "disabled refused", taken, 0);
    offer(6, 32'h20, 32'h20, 32'h1200);
    chk("R2", "other mask refused", taken, 0);
    offer(7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1200);
    chk("R2", "above NLEVEL refused", taken, 0);
    chk("R3", "ps kept", ps, 8'h00);
    chk("R3", "epc6 kept", epc_slot(6), 0);
  endtask

  task automatic t_high6();
    write_ps(8'hC0);
    offer(6, 32'h40, 32'h40, 32'h2000);
    chk("R4", "ps upper kept", ps, 8'hD6);
    chk("R4", "epc6", epc_slot(6), 32'h2000);
    chk("R4", "eps6", eps_slot(6), 8'hC0);
    chk("R5", "target6", tgt, 32'h8000_0280);
  endtask

  task automatic t_kernel();
    write_ps(8'h00);
    offer(1, 32'h2, 32'h2, 32'h3000);
    chk("R6", "kernel class", cls, 2);
    chk("R6", "ps", ps, 8'h10);
    chk("R6", "epc1", epc_slot(1), 32'h3000);
    chk("R6", "cause", cause, 4);
    chk("R8", "kernel target", tgt, 32'h8000_0300);
  endtask

  task automatic t_user();
    write_ps(8'h20);
    offer(1, 32'h2, 32'h2, 32'h3100);
    chk("R6", "user class", cls, 1);
    chk("R6", "ps", ps, 8'h30);
    chk("R6", "epc1", epc_slot(1), 32'h3100);
    chk("R8", "user target", tgt, 32'h8000_0340);
  endtask

  task automatic t_double();
    write_ps(8'h10);
    offer(1, 32'h2, 32'h2, 32'h3200);
    chk("R7", "double class", cls, 3);
    chk("R7", "depc", depc, 32'h3200);
    chk("R7", "epc1 kept", epc_slot(1), 32'h3100);
    chk("R7", "ps", ps, 8'h10);
    chk("R8", "double target", tgt, 32'h8000_03C0);
  endtask

  task automatic t_conflict();
    write_ps(8'h00);
    offer(4, 32'h10, 32'h10, 32'h4000, 1, 8'h25);
    chk("R9", "take wins over write", ps, 8'h14);
    chk("R4", "eps4", eps_slot(4), 8'h00);
    write_ps(8'h2A);
    chk("R10", "ps load", ps, 8'h2A);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_alt_double();
    t_high3();
    t_not_above();
    t_masked();
    t_high6();
    t_kernel();
    t_user();
    t_double();
    t_conflict();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule